// File: doc/BRIEF.md
# Codec Control Register Bank with Reset Lock

This block holds the two control registers of a telephone codec. Both are reached through a byte-wide microport, which has an address, a write-data byte and a write strobe, plus a combinational read-back path. The first register at address 0x03 holds the software-reset bit, the two power-down bits and the companding-law select. The second register at address 0x04 holds the serial-port rate code and the port-mode select. The bank turns these bits into plain control outputs for the rest of the device.

The software-reset bit locks its register. While the bit is set, the other bits of register 0x03 are forced to zero and no write can set them. The rate register is also held at its defaults. Leaving reset therefore takes two writes: one write clears the reset bit, and a second write programs the other bits. This avoids a race between releasing reset and changing the power-down or law settings. An active-low hardware reset is applied asynchronously and released on the clock. It returns every bit to its default: mu-law, both paths powered, rate code 000 (2048 kb/s) and serial-port mode 0.

Top module: `ctrlreg_top`

## Requirements
- R1: While hwRstN is low, all outputs take their defaults at once, without waiting for a clock: softRstOut=0, pdFrameOut=0, pdRecvOut=0, lawSel=0 (mu-law), rateSel=000 (2048 kb/s), portMode=0 and rdData=0x00.
- R2: Register 0x03 has this layout: bit 0 is the software reset, bit 1 is pdFrameOut, bit 2 is pdRecvOut and bit 3 is lawSel (1 = A-law). A read returns these bits, and bits 7:4 read 0. A write with bit 0 = 0 while reset is clear loads bits 3:1.
- R3: Register 0x04 has this layout: bits 2:0 are rateSel and bit 3 is portMode. A read returns these bits, and bits 7:4 read 0. A write loads them while reset is clear.
- R4: A write to 0x03 with bit 0 = 1 sets the reset bit. On the same edge it clears bits 3:1 and returns register 0x04 to its defaults, whatever the other data bits are.
- R5: While the reset bit is set, a write to 0x03 with bit 0 = 1 changes nothing, and bits 3:1 stay 0.
- R6: While the reset bit is set, a write to 0x03 with bit 0 = 0 clears only the reset bit, and bits 3:1 stay 0. A second write is needed to set them.
- R7: While the reset bit is set, register 0x04 holds its defaults and ignores writes.
- R8: fullPowerDown is 1 when both pdFrameOut and pdRecvOut are 1, or when hwRstN is low. Otherwise it is 0.
- R9: softRstOut equals the reset bit. It stays high for every cycle the bit is set.
- R10: A read of any address other than 0x03 and 0x04 returns 0x00, and a write to such an address changes nothing.
- R11: A write takes effect on the rising clock edge on which wrEn is high. With wrEn low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| hwRstN | input | 1 | Hardware reset, active low, asynchronous assert |
| wrEn | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr (combinational) |
| softRstOut | output | 1 | Software reset to the device logic |
| pdFrameOut | output | 1 | Framing/interface power-down |
| pdRecvOut | output | 1 | Receive data path power-down |
| fullPowerDown | output | 1 | Full power-down indication |
| lawSel | output | 1 | Companding law, 0 = mu-law, 1 = A-law |
| rateSel | output | 3 | Serial-port rate code |
| portMode | output | 1 | Serial-port mode select |

## Verification
Two functions can land on the same clock edge. A single write to 0x03 may set the reset bit and ask for power-down or A-law in the same data byte. The lock must win, and on that same edge it must also wipe register 0x04. The bench provokes this with 0x0F written while register 0x04 holds non-default values. It then tries to release reset with data 0x0E, which asks for the other bits in the same write. A behavioural model compares all outputs and the read-back on every cycle, and confirms that only the reset bit moved.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;
  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_CTRL1 = 2'd1,
    RD_CTRL2 = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl1;
    logic   wrCtrl2;
    rdSel_e rdSel;
  } regStrobes_t;
endpackage

// File: rtl/ctrlreg_decode.sv
module ctrlreg_decode
  import ctrlreg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CTRL1_ADDR = 3,
  parameter int CTRL2_ADDR = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(CTRL1_ADDR);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(CTRL2_ADDR);

  logic hit1, hit2;

  always_comb begin
    hit1 = (addr == A1);
    hit2 = (addr == A2);
    strobes.wrCtrl1 = wrEn && hit1;
    strobes.wrCtrl2 = wrEn && hit2;
    if (hit1)      strobes.rdSel = RD_CTRL1;
    else if (hit2) strobes.rdSel = RD_CTRL2;
    else           strobes.rdSel = RD_NONE;
  end
endmodule

// File: rtl/ctrlreg_regs.sv
module ctrlreg_regs
  import ctrlreg_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int RATE_W       = 3,
  parameter int RATE_DEFAULT = 0,
  parameter bit MODE_DEFAULT = 1'b0,
  parameter bit LAW_DEFAULT  = 1'b0
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              swRst,
  output logic              pdFrame,
  output logic              pdRecv,
  output logic              lawBit,
  output logic [RATE_W-1:0] rateCode,
  output logic              modeBit
);
  localparam int BIT_RST  = 0;
  localparam int BIT_PDF  = 1;
  localparam int BIT_PDR  = 2;
  localparam int BIT_LAW  = 3;
  localparam int BIT_MODE = RATE_W;
  localparam logic [RATE_W-1:0] RATE_DEF = RATE_W'(RATE_DEFAULT);

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      swRst    <= 1'b0;
      pdFrame  <= 1'b0;
      pdRecv   <= 1'b0;
      lawBit   <= LAW_DEFAULT;
      rateCode <= RATE_DEF;
      modeBit  <= MODE_DEFAULT;
    end else begin
      if (strobes.wrCtrl1) begin
        swRst <= wrData[BIT_RST];
        if (wrData[BIT_RST]) begin
          pdFrame  <= 1'b0;
          pdRecv   <= 1'b0;
          lawBit   <= LAW_DEFAULT;
          rateCode <= RATE_DEF;
          modeBit  <= MODE_DEFAULT;
        end else if (!swRst) begin
          pdFrame <= wrData[BIT_PDF];
          pdRecv  <= wrData[BIT_PDR];
          lawBit  <= wrData[BIT_LAW];
        end
      end
      if (strobes.wrCtrl2 && !swRst) begin
        rateCode <= wrData[RATE_W-1:0];
        modeBit  <= wrData[BIT_MODE];
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strobes.rdSel)
      RD_CTRL1: begin
        rdData[BIT_RST] = swRst;
        rdData[BIT_PDF] = pdFrame;
        rdData[BIT_PDR] = pdRecv;
        rdData[BIT_LAW] = lawBit;
      end
      RD_CTRL2: begin
        rdData[RATE_W-1:0] = rateCode;
        rdData[BIT_MODE]   = modeBit;
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ctrlreg_top.sv
module ctrlreg_top
  import ctrlreg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int RATE_W     = 3,
  parameter int CTRL1_ADDR = 3,
  parameter int CTRL2_ADDR = 4
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              softRstOut,
  output logic              pdFrameOut,
  output logic              pdRecvOut,
  output logic              fullPowerDown,
  output logic              lawSel,
  output logic [RATE_W-1:0] rateSel,
  output logic              portMode
);
  regStrobes_t strobes;

  ctrlreg_decode #(
    .ADDR_W(ADDR_W), .CTRL1_ADDR(CTRL1_ADDR), .CTRL2_ADDR(CTRL2_ADDR)
  ) u_decode (
    .wrEn(wrEn), .addr(addr), .strobes(strobes)
  );

  ctrlreg_regs #(
    .DATA_W(DATA_W), .RATE_W(RATE_W)
  ) u_regs (
    .clk(clk), .hwRstN(hwRstN), .strobes(strobes), .wrData(wrData),
    .rdData(rdData), .swRst(softRstOut), .pdFrame(pdFrameOut),
    .pdRecv(pdRecvOut), .lawBit(lawSel), .rateCode(rateSel),
    .modeBit(portMode)
  );

  assign fullPowerDown = !hwRstN || (pdFrameOut && pdRecvOut);
endmodule

// File: rtl/ctrlreg_chk.sv
module ctrlreg_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int RATE_W     = 3,
  parameter int CTRL1_ADDR = 3,
  parameter int CTRL2_ADDR = 4
) (
  input logic              clk,
  input logic              hwRstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              softRstOut,
  input logic              pdFrameOut,
  input logic              pdRecvOut,
  input logic              fullPowerDown,
  input logic              lawSel,
  input logic [RATE_W-1:0] rateSel,
  input logic              portMode
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(CTRL1_ADDR);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(CTRL2_ADDR);

  // R5
  lock_clear_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    softRstOut |-> (!pdFrameOut && !pdRecvOut && !lawSel));

  // R4
  enter_rst_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (wrEn && addr == A1 && wrData[0]) |=> (softRstOut && rateSel == '0 && !portMode));

  // R6
  two_step_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (wrEn && addr == A1 && !wrData[0] && softRstOut)
      |=> (!softRstOut && !pdFrameOut && !pdRecvOut && !lawSel));

  // R3
  ctrl2_load_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (wrEn && addr == A2 && !softRstOut) |=> (rateSel == $past(wrData[RATE_W-1:0])));

  // R7
  ctrl2_hold_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    softRstOut |-> (rateSel == '0 && !portMode));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (addr != A1 && addr != A2) |-> (rdData == '0));

  // R8
  full_pd_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (pdFrameOut && pdRecvOut) |-> fullPowerDown);

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    !wrEn |=> ($stable(softRstOut) && $stable(pdFrameOut) && $stable(pdRecvOut)
               && $stable(lawSel) && $stable(rateSel) && $stable(portMode)));
endmodule

bind ctrlreg_top ctrlreg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATE_W(RATE_W),
  .CTRL1_ADDR(CTRL1_ADDR), .CTRL2_ADDR(CTRL2_ADDR)
) u_chk (
  .clk(clk), .hwRstN(hwRstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .softRstOut(softRstOut), .pdFrameOut(pdFrameOut),
  .pdRecvOut(pdRecvOut), .fullPowerDown(fullPowerDown), .lawSel(lawSel),
  .rateSel(rateSel), .portMode(portMode)
);

// File: tb/ctrlreg_top_bench.sv
`timescale 1ns/1ps
module ctrlreg_top_bench;
  logic       clk = 1'b0;
  logic       hwRstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       softRstOut, pdFrameOut, pdRecvOut, fullPowerDown, lawSel, portMode;
  logic [2:0] rateSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int mRst = 0, mPdF = 0, mPdR = 0, mLaw = 0, mRate = 0, mMode = 0;

  always #2.5 clk = ~clk;

  ctrlreg_top u_ctrlreg_top (
    .clk(clk), .hwRstN(hwRstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .softRstOut(softRstOut), .pdFrameOut(pdFrameOut),
    .pdRecvOut(pdRecvOut), .fullPowerDown(fullPowerDown), .lawSel(lawSel),
    .rateSel(rateSel), .portMode(portMode)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mRst = 0; mPdF = 0; mPdR = 0; mLaw = 0; mRate = 0; mMode = 0;
  endtask

  // behavioural rules applied at a clock edge
  task automatic modelEdge();
    if (!hwRstN) begin
      modelReset();
    end else if (wrEn && addr == 8'h03) begin
      if (wrData[0]) begin
        mRst = 1; mPdF = 0; mPdR = 0; mLaw = 0; mRate = 0; mMode = 0;
      end else if (mRst == 1) begin
        mRst = 0;
      end else begin
        mPdF = wrData[1]; mPdR = wrData[2]; mLaw = wrData[3];
      end
    end else if (wrEn && addr == 8'h04 && mRst == 0) begin
      mRate = wrData[2:0]; mMode = wrData[3];
    end
  endtask

  function automatic int expRead();
    if (!hwRstN) return 0;
    if (addr == 8'h03) return mRst | (mPdF << 1) | (mPdR << 2) | (mLaw << 3);
    if (addr == 8'h04) return mRate | (mMode << 3);
    return 0;
  endfunction

  task automatic compareAll(string tag);
    chk({tag, " R9 softRstOut"}, softRstOut, mRst);
    chk({tag, " R2 pdFrameOut"}, pdFrameOut, mPdF);
    chk({tag, " R2 pdRecvOut"}, pdRecvOut, mPdR);
    chk({tag, " R2 lawSel"}, lawSel, mLaw);
    chk({tag, " R3 rateSel"}, rateSel, mRate);
    chk({tag, " R3 portMode"}, portMode, mMode);
    chk({tag, " R8 fullPowerDown"}, fullPowerDown,
        (!hwRstN || (mPdF == 1 && mPdR == 1)) ? 1 : 0);
    chk({tag, " R10 rdData"}, rdData, expRead());
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(string tag, logic we, logic [7:0] a, logic [7:0] d);
    wrEn = we; addr = a; wrData = d;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic rd(string tag, logic [7:0] a);
    cyc(tag, 1'b0, a, 8'hA5);
  endtask

  initial begin
    @(negedge clk);
    modelReset();
    compareAll("R1 reset-state");
    hwRstN = 1'b1;
    rd("R1 after-release", 8'h03);
    rd("R1 ctrl2-default", 8'h04);

    cyc("R2 ctrl1-write", 1'b1, 8'h03, 8'h0E);
    rd("R2 ctrl1-readback", 8'h03);
    cyc("R3 ctrl2-write", 1'b1, 8'h04, 8'hFD);
    rd("R3 ctrl2-readback", 8'h04);
    cyc("R10 unmapped-write", 1'b1, 8'h05, 8'hFF);
    rd("R10 unmapped-read", 8'h05);
    rd("R11 idle", 8'h03);

    // R4: reset bit set together with other bits; ctrl2 wiped
    cyc("R4 enter-reset", 1'b1, 8'h03, 8'h0F);
    rd("R4 ctrl2-after-entry", 8'h04);
    cyc("R5 rewrite-locked", 1'b1, 8'h03, 8'h0F);
    cyc("R7 ctrl2-ignored", 1'b1, 8'h04, 8'h0F);
    rd("R7 ctrl2-read", 8'h04);
    cyc("R6 release-only", 1'b1, 8'h03, 8'h0E);
    rd("R6 others-still-0", 8'h03);
    cyc("R6 second-write", 1'b1, 8'h03, 8'h06);
    rd("R8 full-pd", 8'h03);
    cyc("R3 ctrl2-after-release", 1'b1, 8'h04, 8'h03);

    // R1: asynchronous hardware reset mid-cycle
    #1 hwRstN = 1'b0;
    #0.5;
    modelReset();
    compareAll("R1 async");
    @(negedge clk);
    compareAll("R1 held");
    hwRstN = 1'b1;
    rd("R1 released", 8'h04);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [7:0] d;
      a = 8'(2 + ($urandom % 4));
      d = 8'($urandom);
      cyc("R11 mixed", 1'($urandom % 2), a, d);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule